// File: doc/BRIEF.md
# Serial Temperature-Monitor Register Slave

This block is the two-wire bus target for a temperature-monitoring datapath. It oversamples the bus clock and data lines with the fast system clock, recognises START and STOP, decodes its 7-bit target address and moves bytes in both directions. It pulls the data line low through an open-drain enable. A host first writes a one-byte index that selects one of four registers. It then writes that register or reads it back, either in the same transfer after a repeated START or in a later transfer.

The register set has a 9-bit temperature value that the sensing datapath supplies and the bus can only read. It also has two writable 9-bit thresholds (an upper trip point and a lower release point) and a configuration byte. These three writable registers are driven out to the comparator logic that sits next to this block. Every read transfer emits a single-cycle strobe, so that neighbouring logic can clear a latched alarm.

Top module: `i2c_sensor_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper four bits are 1001 and its next three bits equal `addr_sel`. Bit 0 of the address byte selects read (1) or write (0). A non-matching address gets no acknowledge and leaves every register unchanged.
- R2: The first byte written after the address is the index. Its bits 1:0 select the register: 00 temperature, 01 configuration, 10 lower threshold, 11 upper threshold. The index is kept after STOP and is used by later reads that carry no index byte. It is 00 after reset.
- R3: A 9-bit register moves as a 16-bit word, high byte first and MSB first. The value sits in word bits 15:7, and bits 6:0 read as 0. Any byte read past the register's width reads as 0x00.
- R4: The configuration register is one byte. Bits 4:0 store the written value, bits 7:5 always read 0, and the stored byte appears on `cfg_out`.
- R5: After reset the upper threshold is 0x0A0, the lower threshold is 0x096, the configuration is 0x00 and SDA is released.
- R6: A threshold changes only once its second (low) byte has been acknowledged. A transfer cut short after the high byte changes nothing. Writes aimed at the temperature index change nothing, and bytes past a register's width are acknowledged but have no effect.
- R7: The block acknowledges every matched address byte and every written byte by holding SDA low through the ninth clock. It changes its SDA drive only while SCL is low.
- R8: During a read, a master acknowledge fetches the next byte. A master NACK makes the block release SDA and ignore further clocks until the next START.
- R9: `reg_read_pulse` is high for exactly one system clock per read transfer, when the first data byte is loaded. Write transfers and unmatched addresses never raise it.
- R10: A START seen in any state abandons the current transfer and restarts address reception. After an index write, a repeated START followed by a read returns the newly selected register, and a threshold write cut off by the repeated START changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| addr_sel | input | 3 | Low three bits of the target address |
| temp_val | input | 9 | Current temperature, two's complement, half-degree units |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_read_pulse | output | 1 | One-cycle strobe on each read transfer |
| cfg_out | output | 8 | Configuration byte |
| set_point | output | 9 | Upper threshold |
| hyst_val | output | 9 | Lower threshold |

## Verification
An SCL or SDA change reaches the byte engine two system clocks later through the synchronizer, and the engine's registered response (a new SDA drive, a committed register, the read strobe) follows one clock after that. SDA drive therefore settles about three clocks after SCL falls. The bench drives the bus with a quarter period of six clocks and samples SDA in the middle of each high phase, well clear of that settling window. Register outputs are compared only after the STOP of the transfer that wrote them, and the read strobe is counted over whole transfers rather than sampled at a single cycle.

// File: rtl/sensreg_pkg.sv
package sensreg_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } bus_state_t;

   // Index codes: neighbouring software depends on these values
   localparam logic [1:0] SEL_TEMP  = 2'b00;
   localparam logic [1:0] SEL_CFG   = 2'b01;
   localparam logic [1:0] SEL_HYST  = 2'b10;
   localparam logic [1:0] SEL_SETPT = 2'b11;
endpackage

// File: rtl/sensreg_sync.sv
module sensreg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sensreg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sensreg_regs.sv
module sensreg_regs
   import sensreg_pkg::*;
#(
   parameter int             VAL_W     = 9,
   parameter int             CFG_KEEP  = 5,
   parameter logic [VAL_W-1:0] SETPT_RST = 'h0A0,
   parameter logic [VAL_W-1:0] HYST_RST  = 'h096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_we,
   input  logic [1:0]        ptr_d,
   input  logic              cfg_we,
   input  logic [BYTE_W-1:0] cfg_d,
   input  logic              val_we,
   input  logic [VAL_W-1:0]  val_d,
   input  logic [VAL_W-1:0]  temp_val,
   output logic [1:0]        ptr_q,
   output logic [BYTE_W-1:0] cfg_q,
   output logic [VAL_W-1:0]  setpt_q,
   output logic [VAL_W-1:0]  hyst_q,
   output logic [WORD_W-1:0] rd_word
);
   localparam int PAD_W = WORD_W - VAL_W;

   generate
      if (VAL_W <= BYTE_W || VAL_W > WORD_W) begin : g_bad_width
         $error("sensreg_regs: VAL_W must span two bytes");
      end
      if (CFG_KEEP < 1 || CFG_KEEP > BYTE_W) begin : g_bad_cfg
         $error("sensreg_regs: CFG_KEEP out of range");
      end
   endgenerate

   logic [CFG_KEEP-1:0] cfg_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= SEL_TEMP;
         cfg_bits <= '0;
      end else begin
         if (ptr_we) ptr_q <= ptr_d;
         if (cfg_we) cfg_bits <= cfg_d[CFG_KEEP-1:0];
      end
   end

   generate
      if (CFG_KEEP < BYTE_W) begin : g_cfg_pad
         assign cfg_q = {{(BYTE_W-CFG_KEEP){1'b0}}, cfg_bits};
      end else begin : g_cfg_full
         assign cfg_q = cfg_bits;
      end
   endgenerate

   // Threshold pair: index 0 = lower (hysteresis), index 1 = upper (set point)
   generate
      for (genvar k = 0; k < 2; k++) begin : g_thr
         localparam logic [1:0]       CODE = (k == 0) ? SEL_HYST : SEL_SETPT;
         localparam logic [VAL_W-1:0] INIT = (k == 0) ? HYST_RST : SETPT_RST;
         logic [VAL_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       r <= INIT;
            else if (val_we && ptr_q == CODE) r <= val_d;
         end
      end
   endgenerate

   assign hyst_q  = g_thr[0].r;
   assign setpt_q = g_thr[1].r;

   function automatic logic [WORD_W-1:0] left_just(input logic [VAL_W-1:0] v);
      logic [WORD_W-1:0] w;
      w = '0;
      w[WORD_W-1 -: VAL_W] = v;
      return w;
   endfunction

   always_comb begin
      unique case (ptr_q)
         SEL_TEMP:  rd_word = left_just(temp_val);
         SEL_CFG:   rd_word = {cfg_q, {BYTE_W{1'b0}}};
         SEL_HYST:  rd_word = left_just(hyst_q);
         default:   rd_word = left_just(setpt_q);
      endcase
   end

   logic unused_pad;
   assign unused_pad = (PAD_W < 0);
endmodule

// File: rtl/i2c_sensor_regs.sv
module i2c_sensor_regs
   import sensreg_pkg::*;
#(
   parameter int               VAL_W       = 9,
   parameter int               SYNC_STAGES = 2,
   parameter int               ADDR_PINS   = 3,
   parameter logic [6:0]       DEV_BASE    = 7'b1001000,
   parameter logic [VAL_W-1:0] SETPT_RST   = 'h0A0,
   parameter logic [VAL_W-1:0] HYST_RST    = 'h096
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic [ADDR_PINS-1:0] addr_sel,
   input  logic [VAL_W-1:0]     temp_val,
   output logic                 sda_oe,
   output logic                 reg_read_pulse,
   output logic [BYTE_W-1:0]    cfg_out,
   output logic [VAL_W-1:0]     set_point,
   output logic [VAL_W-1:0]     hyst_val
);
   localparam logic [3:0] BITS_PER_BYTE = 4'd8;
   localparam logic [3:0] LAST_BIT      = 4'd7;

   generate
      if (ADDR_PINS < 1 || ADDR_PINS > 6) begin : g_bad_pins
         $error("i2c_sensor_regs: ADDR_PINS out of range");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   sensreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   bus_state_t        state;
   logic [3:0]        bitcnt;
   logic [1:0]        byte_idx;
   logic              rw_q, nack_q;
   logic [BYTE_W-1:0] shreg, txsh, msb_hold;
   logic [WORD_W-1:0] rd_latch, rd_word, wr_word;
   logic [1:0]        ptr_q;
   logic              ack_end, ptr_we, cfg_we, val_we, addr_hit;
   logic [BYTE_W-1:0] next_byte;

   assign addr_hit  = (shreg[BYTE_W-1:ADDR_PINS+1] == DEV_BASE[6:ADDR_PINS])
                   && (shreg[ADDR_PINS:1] == addr_sel);
   assign ack_end   = (state == ST_WR_ACK) && scl_fall;
   assign ptr_we    = ack_end && (byte_idx == 2'd0);
   assign cfg_we    = ack_end && (byte_idx == 2'd1) && (ptr_q == SEL_CFG);
   assign val_we    = ack_end && (byte_idx == 2'd2)
                   && (ptr_q == SEL_HYST || ptr_q == SEL_SETPT);
   assign wr_word   = {msb_hold, shreg};
   assign next_byte = (byte_idx == 2'd0) ? rd_latch[BYTE_W-1:0] : '0;

   sensreg_regs #(
      .VAL_W(VAL_W), .CFG_KEEP(5), .SETPT_RST(SETPT_RST), .HYST_RST(HYST_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ptr_we(ptr_we), .ptr_d(shreg[1:0]),
      .cfg_we(cfg_we), .cfg_d(shreg),
      .val_we(val_we), .val_d(wr_word[WORD_W-1 -: VAL_W]),
      .temp_val(temp_val),
      .ptr_q(ptr_q), .cfg_q(cfg_out), .setpt_q(set_point), .hyst_q(hyst_val),
      .rd_word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         bitcnt         <= '0;
         byte_idx       <= '0;
         rw_q           <= 1'b0;
         nack_q         <= 1'b0;
         shreg          <= '0;
         txsh           <= '0;
         msb_hold       <= '0;
         rd_latch       <= '0;
         sda_oe         <= 1'b0;
         reg_read_pulse <= 1'b0;
      end else begin
         reg_read_pulse <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR_BYTE: begin
                  if (scl_rise && bitcnt != BITS_PER_BYTE) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == BITS_PER_BYTE) begin
                     if (state == ST_WR_BYTE) begin
                        sda_oe <= 1'b1;
                        state  <= ST_WR_ACK;
                     end else if (addr_hit) begin
                        sda_oe <= 1'b1;
                        rw_q   <= shreg[0];
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt   <= '0;
                     byte_idx <= '0;
                     if (rw_q) begin
                        rd_latch       <= rd_word;
                        txsh           <= rd_word[WORD_W-1 -: BYTE_W];
                        sda_oe         <= ~rd_word[WORD_W-1];
                        reg_read_pulse <= 1'b1;
                        state          <= ST_RD_BYTE;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR_BYTE;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WR_BYTE;
                     if (byte_idx == 2'd1) msb_hold <= shreg;
                     if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RD_ACK;
                     end else begin
                        txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txsh[BYTE_W-2];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        state <= ST_IDLE;
                     end else begin
                        if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                        txsh   <= next_byte;
                        sda_oe <= ~next_byte[BYTE_W-1];
                        state  <= ST_RD_BYTE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sensreg_chk.sv
module sensreg_chk
   import sensreg_pkg::*;
#(
   parameter int VAL_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              stop_det,
   input logic              val_we,
   input bus_state_t        state,
   input logic              sda_oe,
   input logic              reg_read_pulse,
   input logic [BYTE_W-1:0] cfg_out,
   input logic [VAL_W-1:0]  set_point,
   input logic [VAL_W-1:0]  hyst_val
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_read_pulse |=> !reg_read_pulse);                                  // R9
   AST_PULSE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && reg_read_pulse) |-> $past(state) == ST_ADDR_ACK);         // R9
   AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out[BYTE_W-1:5] == '0);                                           // R4
   AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && scl_s && $past(scl_s)) |-> $stable(sda_oe));              // R7
   AST_SETPT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$stable(set_point)) |-> $past(val_we));                  // R6
   AST_HYST_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$stable(hyst_val)) |-> $past(val_we));                   // R6
   AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(stop_det)) |-> !sda_oe);                            // R8
endmodule

bind i2c_sensor_regs sensreg_chk #(.VAL_W(VAL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det), .val_we(val_we),
   .state(state), .sda_oe(sda_oe), .reg_read_pulse(reg_read_pulse),
   .cfg_out(cfg_out), .set_point(set_point), .hyst_val(hyst_val)
);

// File: tb/i2c_sensor_regs_test.sv
module i2c_sensor_regs_test;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       msda = 1'b1;
   logic [2:0] asel = 3'b101;
   logic [8:0] temp = 9'h1CE;
   logic       sda_oe, reg_read_pulse;
   logic [7:0] cfg_out;
   logic [8:0] set_point, hyst_val;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   logic [8:0] exp_setpt = 9'h0A0;
   logic [8:0] exp_hyst  = 9'h096;
   logic [7:0] exp_cfg   = 8'h00;

   assign sda_line = msda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_sensor_regs uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .addr_sel(asel), .temp_val(temp), .sda_oe(sda_oe),
      .reg_read_pulse(reg_read_pulse), .cfg_out(cfg_out),
      .set_point(set_point), .hyst_val(hyst_val)
   );

   always @(posedge clk) if (reg_read_pulse) pulses++;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_start();
      msda = 1'b1; tick(Q); scl = 1'b1; tick(Q); msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      msda = 1'b0; tick(Q); scl = 1'b1; tick(Q); msda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         msda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(1);
      end
      msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      acked = !sda_line;
      tick(Q); scl = 1'b0; tick(1);
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q); scl = 1'b0; tick(1);
      end
      msda = nack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(1);
      msda = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic [2:0] a, input bit rd);
      return {4'b1001, a, rd};
   endfunction

   task automatic wr_xfer(input logic [1:0] ptr, input int n,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, output int nacks);
      bit a;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      nacks = 0;
      bus_start();
      send_byte(dev(asel, 1'b0), a); if (!a) nacks++;
      send_byte({6'b0, ptr}, a);     if (!a) nacks++;
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], a); if (!a) nacks++;
      end
      bus_stop();
   endtask

   task automatic rd_xfer(input bit set_ptr, input logic [1:0] ptr, input int n,
                          output logic [23:0] data);
      bit a;
      logic [7:0] b;
      data = '0;
      bus_start();
      if (set_ptr) begin
         send_byte(dev(asel, 1'b0), a);
         send_byte({6'b0, ptr}, a);
         bus_start();
      end
      send_byte(dev(asel, 1'b1), a);
      chk(a, "R1", "read address ack", 32'(a), 32'd1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n-1, b);
         data = {data[15:0], b};
      end
      bus_stop();
   endtask

   initial begin
      int nk;
      int p0;
      bit a;
      logic [23:0] rd;
      logic [8:0] v;
      logic [7:0] b;

      tick(5);
      // R5 reset state
      chk(set_point == 9'h0A0, "R5", "upper threshold", 32'(set_point), 32'h0A0);
      chk(hyst_val == 9'h096, "R5", "lower threshold", 32'(hyst_val), 32'h096);
      chk(cfg_out == 8'h00, "R5", "configuration", 32'(cfg_out), 32'h0);
      chk(sda_oe == 1'b0, "R5", "sda released", 32'(sda_oe), 32'h0);
      rst_n = 1'b1;
      tick(5);

      // R2 R3 R9: read with no index write uses index 00 (temperature)
      p0 = pulses;
      rd_xfer(1'b0, 2'b00, 2, rd);
      chk(rd[15:0] == {temp, 7'b0}, "R2", "default index temperature", 32'(rd[15:0]), 32'({temp, 7'b0}));
      chk(pulses == p0 + 1, "R9", "one strobe per read", 32'(pulses - p0), 32'd1);

      // R1 address sweep over every pin setting and every candidate
      for (int s = 0; s < 8; s++) begin
         asel = 3'(s);
         tick(2);
         for (int c = 0; c < 8; c++) begin
            bus_start();
            send_byte(dev(3'(c), 1'b0), a);
            bus_stop();
            chk(a == (c == s), "R1", "address match ack", 32'(a), 32'(c == s));
         end
         bus_start();
         send_byte({4'b1101, 3'(s), 1'b0}, a);
         bus_stop();
         chk(!a, "R1", "wrong prefix ack", 32'(a), 32'd0);
         p0 = pulses;
         bus_start();
         send_byte(dev(3'(s) ^ 3'b010, 1'b1), a);
         bus_stop();
         chk(pulses == p0, "R9", "no strobe on unmatched read", 32'(pulses - p0), 32'd0);
      end
      asel = 3'b101;
      tick(2);

      // R4 configuration byte
      p0 = pulses;
      wr_xfer(2'b01, 1, 8'hFF, 8'h00, 8'h00, nk);
      chk(nk == 0, "R7", "config write acks", 32'(nk), 32'd0);
      chk(cfg_out == 8'h1F, "R4", "config upper bits cleared", 32'(cfg_out), 32'h1F);
      chk(pulses == p0, "R9", "no strobe on write", 32'(pulses - p0), 32'd0);
      rd_xfer(1'b1, 2'b01, 2, rd);
      chk(rd[15:0] == 16'h1F00, "R4", "config readback", 32'(rd[15:0]), 32'h1F00);
      wr_xfer(2'b01, 1, 8'h0A, 8'h00, 8'h00, nk);
      exp_cfg = 8'h0A;
      chk(cfg_out == exp_cfg, "R4", "config rewrite", 32'(cfg_out), 32'(exp_cfg));

      // R6 R3 R10 threshold sweep with readback after repeated start
      for (int k = 0; k < 16; k++) begin
         logic [1:0] p;
         v = 9'((k * 83 + 7) & 9'h1FF);
         if (k == 0) v = 9'h000;
         if (k == 1) v = 9'h1FF;
         if (k == 2) v = 9'h100;
         if (k == 3) v = 9'h0FF;
         p = (k % 2 == 1) ? 2'b11 : 2'b10;
         wr_xfer(p, 2, v[8:1], {v[0], 7'b1010101}, 8'h00, nk);
         if (p == 2'b11) exp_setpt = v; else exp_hyst = v;
         chk(nk == 0, "R7", "threshold write acks", 32'(nk), 32'd0);
         chk(set_point == exp_setpt, "R6", "upper after write", 32'(set_point), 32'(exp_setpt));
         chk(hyst_val == exp_hyst, "R6", "lower after write", 32'(hyst_val), 32'(exp_hyst));
         rd_xfer(1'b1, p, 2, rd);
         chk(rd[15:0] == {v, 7'b0}, "R10", "readback via repeated start", 32'(rd[15:0]), 32'({v, 7'b0}));
      end

      // R6 transfer cut after high byte changes nothing
      wr_xfer(2'b11, 1, 8'hAA, 8'h00, 8'h00, nk);
      chk(set_point == exp_setpt, "R6", "partial write ignored", 32'(set_point), 32'(exp_setpt));

      // R6 writes to temperature index ignored
      wr_xfer(2'b00, 2, 8'h55, 8'h80, 8'h00, nk);
      chk(nk == 0, "R7", "temperature write still acked", 32'(nk), 32'd0);
      chk(set_point == exp_setpt && hyst_val == exp_hyst && cfg_out == exp_cfg,
          "R6", "temperature write no effect", 32'(set_point), 32'(exp_setpt));
      rd_xfer(1'b0, 2'b00, 2, rd);
      chk(rd[15:0] == {temp, 7'b0}, "R6", "temperature unchanged", 32'(rd[15:0]), 32'({temp, 7'b0}));

      // R6 R7 extra bytes acknowledged and ignored
      wr_xfer(2'b10, 3, 8'h3C, 8'h80, 8'hFF, nk);
      exp_hyst = 9'h079;
      chk(nk == 0, "R7", "extra byte acked", 32'(nk), 32'd0);
      chk(hyst_val == exp_hyst, "R6", "extra byte ignored", 32'(hyst_val), 32'(exp_hyst));

      // R10 repeated start mid-write aborts; read uses new index 11
      p0 = pulses;
      bus_start();
      send_byte(dev(asel, 1'b0), a);
      send_byte(8'h03, a);
      send_byte(8'h11, a);
      bus_start();
      send_byte(dev(asel, 1'b1), a);
      recv_byte(1'b0, b); rd[15:8] = b;
      recv_byte(1'b1, b); rd[7:0] = b;
      bus_stop();
      chk(set_point == exp_setpt, "R10", "aborted write no effect", 32'(set_point), 32'(exp_setpt));
      chk(rd[15:0] == {exp_setpt, 7'b0}, "R10", "read of new index", 32'(rd[15:0]), 32'({exp_setpt, 7'b0}));
      chk(pulses == p0 + 1, "R9", "strobe count repeated start", 32'(pulses - p0), 32'd1);

      // R2 index persists across transfers
      wr_xfer(2'b10, 0, 8'h00, 8'h00, 8'h00, nk);
      rd_xfer(1'b0, 2'b00, 2, rd);
      chk(rd[15:0] == {exp_hyst, 7'b0}, "R2", "stored index reused", 32'(rd[15:0]), 32'({exp_hyst, 7'b0}));

      // R3 bytes past width read 0
      rd_xfer(1'b0, 2'b00, 3, rd);
      chk(rd == {exp_hyst, 15'b0}, "R3", "third byte zero", 32'(rd), 32'({exp_hyst, 15'b0}));

      // R8 NACK releases SDA and later clocks are ignored
      bus_start();
      send_byte(dev(asel, 1'b1), a);
      recv_byte(1'b1, b);
      tick(Q);
      chk(sda_oe == 1'b0, "R8", "released after nack", 32'(sda_oe), 32'd0);
      recv_byte(1'b1, b);
      chk(b == 8'hFF, "R8", "ignored clocks after nack", 32'(b), 32'hFF);
      bus_stop();

      // R3 temperature sweep with index 00
      wr_xfer(2'b00, 0, 8'h00, 8'h00, 8'h00, nk);
      for (int t = 0; t < 16; t++) begin
         temp = 9'((t * 37 + 256) & 9'h1FF);
         tick(2);
         rd_xfer(1'b0, 2'b00, 2, rd);
         chk(rd[15:0] == {temp, 7'b0}, "R3", "temperature word", 32'(rd[15:0]), 32'({temp, 7'b0}));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule